// File: doc/BRIEF.md
# Configuration Scrubber Start-up Sequencer

This block takes a configuration-memory error-mitigation engine out of reset and hands it over to its steady observation phase. After reset is released it sits in a boot phase with every status flag low. It will not touch the configuration access port until an externally driven grant has been seen. The grant comes from another clock domain and passes through a synchronizer chain first. Once the grant is taken, the block enters initialization. It raises a one-cycle report request for the monitor output. It then keeps reading the device identification word until the vendor field matches. Between failed reads it waits a programmable number of idle cycles.

With the identity confirmed, the block runs its readback passes in order, each as a start pulse answered by a done pulse. The three base passes (per-frame ECC, device CRC, extra checksum) always run. A fourth pass, which builds the per-frame CRC table, runs only when the enhanced-repair mode was selected at the moment initialization began. After the done of the last required pass, the block reports observation and stays there. The readback engine, the checksum arithmetic and the port protocol sit outside this block.

The ID read path is a stream pair. The request channel holds `id_req_valid` until `id_req_ready` is sampled high. The response channel accepts a word only in a cycle where both `id_rsp_valid` and `id_rsp_ready` are high. The responder may stall the request for any number of cycles. A response offered while `id_rsp_ready` is low is simply not taken.

Top module: `cfg_scrub_init_seq`

## Requirements
- R1: While reset is high and throughout the boot phase, `status` is all zero. In that time `id_req_valid`, `pass_start` and `report_req` stay low.
- R2: The grant is sampled through a two-stage synchronizer. If `grant_async` is high at a rising edge, `status[0]` (initializing) is still low after that edge and the next one, and is high after the third.
- R3: Once initialization has begun, deasserting `grant_async` has no effect: `status[0]` stays high.
- R4: `report_req` is high for exactly one cycle: the first cycle in which `status[0]` is high.
- R5: `id_req_valid` rises in the first initialization cycle and stays high until a cycle with `id_req_ready` high. After that handshake it drops, and `id_rsp_ready` is high until a response is accepted.
- R6: When a response does not match, `id_req_valid` stays low for exactly `poll_gap` cycles and then rises again. With `poll_gap` = 0 it is high in the very next cycle.
- R7: A response matches when bits 11:0 equal 0x093, whatever the other bits hold. In the cycle after the accepted matching response, `pass_start` is high with `pass_idx` = 0.
- R8: Passes start in the order 0 (frame ECC), 1 (device CRC), 2 (extra checksum), 3 (frame CRC table). Each `pass_start` lasts one cycle. The next pass starts in the cycle after `pass_done` is seen for the current one.
- R9: Pass 3 runs only if `enh_repair` was high at the edge where initialization began. Later changes of `enh_repair` have no effect.
- R10: After `pass_done` for the last required pass, `status` reads 5'b00010 (observing) in the next cycle and stays there.
- R11: `pass_done` outside a running pass, and an ID response while `id_rsp_ready` is low, change neither the outputs nor the progress.
- R12: `status[4:2]` (correction, classification, injection flags) are always zero in this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Global reset, active high |
| grant_async | input | 1 | Access grant from another domain, unsynchronized |
| enh_repair | input | 1 | Enhanced-repair mode select, sampled at initialization entry |
| poll_gap | input | GAP_W | Idle cycles between ID polls |
| id_req_valid | output | 1 | ID read request valid |
| id_req_ready | input | 1 | ID read request accepted |
| id_rsp_valid | input | 1 | ID response word valid |
| id_rsp_ready | output | 1 | Sequencer is waiting for an ID response |
| id_rsp_data | input | ID_W | Returned identification word |
| pass_start | output | 1 | One-cycle start of a readback pass |
| pass_idx | output | PASS_W | Index of the current readback pass |
| pass_done | input | 1 | Completion pulse of the running pass |
| report_req | output | 1 | One-cycle monitor report request |
| status | output | 5 | Bit 0 initializing, bit 1 observing, bits 4:2 zero |

## Verification
The hardest situations to reach are the stray inputs: a response word offered while the sequencer is in its idle gap or still holding a request, and done pulses that arrive before any pass or after observation. The stimulus places each of these deliberately at the port, in a cycle where the FSM is known to be waiting elsewhere. It then checks that neither the status nor the pass stream moved. The gap length is measured by counting low cycles of `id_req_valid` after a rejected word. The mode input is flipped right after initialization entry to show that the optional pass follows the latched value.

// File: rtl/cbi_pkg.sv
package cbi_pkg;
  localparam int STATUS_W  = 5;
  localparam int ST_INIT   = 0;
  localparam int ST_OBSERVE = 1;

  typedef enum logic [1:0] {PH_BOOT, PH_IDCHK, PH_PASSES, PH_OBSERVE} phase_e;
  typedef enum logic [1:0] {PL_IDLE, PL_REQ, PL_RSP, PL_GAP} poll_e;
  typedef enum logic [1:0] {PS_IDLE, PS_START, PS_WAIT} step_e;
endpackage

// File: rtl/cbi_grant_sync.sv
module cbi_grant_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign q = chain[STAGES-1];

  // each stage copies its predecessor one edge later
  for (genvar i = 1; i < STAGES; i++) begin : g_stage_chk
    a_r2_stage_shift: assert property (@(posedge clk) disable iff (rst)
      chain[i] == $past(chain[i-1]));
  end
endmodule

// File: rtl/cbi_id_poller.sv
module cbi_id_poller import cbi_pkg::*; #(
  parameter int              ID_W      = 32,
  parameter logic [ID_W-1:0] ID_EXPECT = 32'h0000_0093,
  parameter logic [ID_W-1:0] ID_MASK   = 32'h0000_0FFF,
  parameter int              GAP_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [GAP_W-1:0] gap,
  output logic             req_valid,
  input  logic             req_ready,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [ID_W-1:0]  rsp_data,
  output logic             found
);
  localparam logic [ID_W-1:0] KEY = ID_EXPECT & ID_MASK;

  poll_e            st;
  logic [GAP_W-1:0] cnt;
  logic             hit;

  assign hit       = (rsp_data & ID_MASK) == KEY;
  assign req_valid = (st == PL_REQ);
  assign rsp_ready = (st == PL_RSP);
  assign found     = rsp_valid && rsp_ready && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= PL_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        PL_IDLE: if (go) st <= PL_REQ;
        PL_REQ:  if (req_ready) st <= PL_RSP;
        PL_RSP: begin
          if (rsp_valid) begin
            if (hit)            st <= PL_IDLE;
            else if (gap == '0) st <= PL_REQ;
            else begin
              st  <= PL_GAP;
              cnt <= gap - GAP_W'(1);
            end
          end
        end
        PL_GAP: begin
          if (cnt == '0) st <= PL_REQ;
          else           cnt <= cnt - GAP_W'(1);
        end
        default: st <= PL_IDLE;
      endcase
    end
  end

  a_r5_req_held: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> req_valid);

  a_r5_req_then_rsp: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (rsp_ready && !req_valid));

  a_r7_found_stops: assert property (@(posedge clk) disable iff (rst)
    found |=> (!req_valid && !rsp_ready));
endmodule

// File: rtl/cbi_pass_stepper.sv
module cbi_pass_stepper import cbi_pkg::*; #(
  parameter int PASS_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [PASS_W-1:0] last_idx,
  input  logic              pass_done,
  output logic              pass_start,
  output logic [PASS_W-1:0] pass_idx,
  output logic              finished
);
  step_e             st;
  logic [PASS_W-1:0] idx;

  assign pass_start = (st == PS_START);
  assign pass_idx   = idx;
  assign finished   = (st == PS_WAIT) && pass_done && (idx == last_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= PS_IDLE;
      idx <= '0;
    end else begin
      case (st)
        PS_IDLE: if (go) begin
          idx <= '0;
          st  <= PS_START;
        end
        PS_START: st <= PS_WAIT;
        PS_WAIT: if (pass_done) begin
          if (idx == last_idx) st <= PS_IDLE;
          else begin
            idx <= idx + PASS_W'(1);
            st  <= PS_START;
          end
        end
        default: st <= PS_IDLE;
      endcase
    end
  end

  a_r8_start_single: assert property (@(posedge clk) disable iff (rst)
    pass_start |=> !pass_start);

  a_r8_idx_advance: assert property (@(posedge clk) disable iff (rst)
    (pass_start && $past(st == PS_WAIT)) |-> (pass_idx == PASS_W'($past(pass_idx) + 1'b1)));

  a_r9_idx_bound: assert property (@(posedge clk) disable iff (rst)
    pass_start |-> (pass_idx <= last_idx));
endmodule

// File: rtl/cfg_scrub_init_seq.sv
module cfg_scrub_init_seq import cbi_pkg::*; #(
  parameter int              ID_W            = 32,
  parameter logic [ID_W-1:0] ID_EXPECT       = 32'h0000_0093,
  parameter logic [ID_W-1:0] ID_MASK         = 32'h0000_0FFF,
  parameter int              GAP_W           = 8,
  parameter int              PASS_W          = 2,
  parameter int              NUM_BASE_PASSES = 3,
  parameter int              SYNC_STAGES     = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                grant_async,
  input  logic                enh_repair,
  input  logic [GAP_W-1:0]    poll_gap,
  output logic                id_req_valid,
  input  logic                id_req_ready,
  input  logic                id_rsp_valid,
  output logic                id_rsp_ready,
  input  logic [ID_W-1:0]     id_rsp_data,
  output logic                pass_start,
  output logic [PASS_W-1:0]   pass_idx,
  input  logic                pass_done,
  output logic                report_req,
  output logic [STATUS_W-1:0] status
);
  localparam logic [PASS_W-1:0] BASE_LAST = PASS_W'(NUM_BASE_PASSES - 1);
  localparam logic [PASS_W-1:0] FULL_LAST = PASS_W'(NUM_BASE_PASSES);

  phase_e            phase;
  logic              grant_s;
  logic              repair_q;
  logic              go_id;
  logic              id_found;
  logic              all_done;
  logic [PASS_W-1:0] last_idx;

  cbi_grant_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (grant_async),
    .q       (grant_s)
  );

  // entering initialization latches the grant and the repair mode
  assign go_id    = (phase == PH_BOOT) && grant_s;
  assign last_idx = repair_q ? FULL_LAST : BASE_LAST;

  cbi_id_poller #(
    .ID_W      (ID_W),
    .ID_EXPECT (ID_EXPECT),
    .ID_MASK   (ID_MASK),
    .GAP_W     (GAP_W)
  ) u_poll (
    .clk       (clk),
    .rst       (rst),
    .go        (go_id),
    .gap       (poll_gap),
    .req_valid (id_req_valid),
    .req_ready (id_req_ready),
    .rsp_valid (id_rsp_valid),
    .rsp_ready (id_rsp_ready),
    .rsp_data  (id_rsp_data),
    .found     (id_found)
  );

  cbi_pass_stepper #(.PASS_W(PASS_W)) u_step (
    .clk        (clk),
    .rst        (rst),
    .go         (id_found),
    .last_idx   (last_idx),
    .pass_done  (pass_done),
    .pass_start (pass_start),
    .pass_idx   (pass_idx),
    .finished   (all_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_BOOT;
      repair_q   <= 1'b0;
      report_req <= 1'b0;
    end else begin
      report_req <= go_id;
      case (phase)
        PH_BOOT: if (go_id) begin
          phase    <= PH_IDCHK;
          repair_q <= enh_repair;
        end
        PH_IDCHK:   if (id_found) phase <= PH_PASSES;
        PH_PASSES:  if (all_done) phase <= PH_OBSERVE;
        PH_OBSERVE: phase <= PH_OBSERVE;
        default:    phase <= PH_BOOT;
      endcase
    end
  end

  always_comb begin
    status              = '0;
    status[ST_INIT]     = (phase == PH_IDCHK) || (phase == PH_PASSES);
    status[ST_OBSERVE]  = (phase == PH_OBSERVE);
  end

  a_r1_boot_quiet: assert property (@(posedge clk) disable iff (rst)
    (status == '0) |-> (!id_req_valid && !pass_start));

  a_r3_init_kept: assert property (@(posedge clk) disable iff (rst)
    status[ST_INIT] |=> (status[ST_INIT] || status[ST_OBSERVE]));

  a_r4_report_first: assert property (@(posedge clk) disable iff (rst)
    report_req |-> (status[ST_INIT] && $past(status == '0)));

  a_r10_observe_sticky: assert property (@(posedge clk) disable iff (rst)
    status[ST_OBSERVE] |=> (status[ST_OBSERVE] && !status[ST_INIT]));
endmodule

// File: tb/sim_cfg_scrub_init_seq.sv
module sim_cfg_scrub_init_seq;
  localparam int CLK_PERIOD = 10;
  localparam int GAP_W  = 8;
  localparam int ID_W   = 32;
  localparam int PASS_W = 2;
  localparam logic [31:0] VENDOR = 32'h0000_0093;

  logic              clk;
  logic              rst;
  logic              grant_async;
  logic              enh_repair;
  logic [GAP_W-1:0]  poll_gap;
  logic              id_req_valid;
  logic              id_req_ready;
  logic              id_rsp_valid;
  logic              id_rsp_ready;
  logic [ID_W-1:0]   id_rsp_data;
  logic              pass_start;
  logic [PASS_W-1:0] pass_idx;
  logic              pass_done;
  logic              report_req;
  logic [4:0]        status;

  int n_chk = 0;
  int n_bad = 0;
  int exp_q[$];

  cfg_scrub_init_seq u0 (
    .clk(clk), .rst(rst), .grant_async(grant_async), .enh_repair(enh_repair),
    .poll_gap(poll_gap), .id_req_valid(id_req_valid), .id_req_ready(id_req_ready),
    .id_rsp_valid(id_rsp_valid), .id_rsp_ready(id_rsp_ready), .id_rsp_data(id_rsp_data),
    .pass_start(pass_start), .pass_idx(pass_idx), .pass_done(pass_done),
    .report_req(report_req), .status(status)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // scoreboard monitor: every pass start is compared with the next expected index
  always @(negedge clk) begin
    if (!rst && pass_start) begin
      int e;
      if (exp_q.size() == 0) chk(1'b0, "R9 pass beyond expected count", int'(pass_idx), -1);
      else begin
        e = exp_q.pop_front();
        chk(int'(pass_idx) == e, "R8 pass order", int'(pass_idx), e);
      end
    end
  end

  task automatic run(input bit enh, input int gap);
    int n;
    int last;
    last = enh ? 3 : 2;
    rst = 1'b1; grant_async = 1'b0; enh_repair = 1'b0; poll_gap = '0;
    id_req_ready = 1'b0; id_rsp_valid = 1'b0; id_rsp_data = '0; pass_done = 1'b0;
    repeat (3) tick();
    chk(status == 5'd0 && !id_req_valid, "R1 reset quiet", int'(status), 0);
    rst = 1'b0;
    repeat (4) begin
      tick();
      chk(status == 5'd0 && !id_req_valid && !pass_start && !report_req,
          "R1 boot quiet", int'(status), 0);
    end
    pass_done = 1'b1; tick(); pass_done = 1'b0;
    chk(status == 5'd0 && !pass_start, "R11 stray done in boot", int'(status), 0);

    enh_repair = enh; poll_gap = GAP_W'(gap); grant_async = 1'b1;
    tick(); chk(status[0] == 1'b0, "R2 first edge", int'(status[0]), 0);
    tick(); chk(status[0] == 1'b0, "R2 second edge", int'(status[0]), 0);
    tick(); chk(status == 5'b00001, "R2 init after third edge", int'(status), 1);
    chk(report_req, "R4 report in first init cycle", int'(report_req), 1);
    grant_async = 1'b0; enh_repair = !enh;
    tick();
    chk(!report_req, "R4 report single cycle", int'(report_req), 0);
    chk(status == 5'b00001, "R3 grant drop ignored", int'(status), 1);

    chk(id_req_valid, "R5 request raised", int'(id_req_valid), 1);
    tick();
    chk(id_req_valid, "R5 request held while stalled", int'(id_req_valid), 1);
    id_req_ready = 1'b1; tick(); id_req_ready = 1'b0;
    chk(!id_req_valid && id_rsp_ready, "R5 request accepted", int'(id_rsp_ready), 1);
    pass_done = 1'b1; tick(); pass_done = 1'b0;
    chk(id_rsp_ready && !pass_start && status == 5'b00001, "R11 stray done during poll",
        int'(pass_start), 0);

    id_rsp_valid = 1'b1; id_rsp_data = 32'h0000_0094; tick(); id_rsp_valid = 1'b0;
    n = 0;
    while (!id_req_valid && n < 300) begin
      n++;
      tick();
    end
    chk(n == gap, "R6 gap after mismatch", n, gap);

    id_rsp_valid = 1'b1; id_rsp_data = VENDOR; tick(); id_rsp_valid = 1'b0;
    chk(id_req_valid && !pass_start && status == 5'b00001,
        "R11 response ignored while not ready", int'(pass_start), 0);

    for (int p = 0; p <= last; p++) exp_q.push_back(p);
    id_req_ready = 1'b1; tick(); id_req_ready = 1'b0;
    id_rsp_valid = 1'b1; id_rsp_data = 32'hDEAD_5093; tick(); id_rsp_valid = 1'b0;
    chk(pass_start && pass_idx == 2'd0, "R7 masked match starts pass 0", int'(pass_idx), 0);

    for (int p = 0; p <= last; p++) begin
      chk(pass_start && int'(pass_idx) == p, "R8 pass started", int'(pass_idx), p);
      tick();
      chk(!pass_start, "R8 start is one cycle", int'(pass_start), 0);
      tick(); tick();
      pass_done = 1'b1; tick(); pass_done = 1'b0;
      if (p == last) chk(status == 5'b00010, "R10 observe after last pass", int'(status), 2);
    end

    pass_done = 1'b1; tick(); pass_done = 1'b0;
    repeat (3) begin
      tick();
      chk(status == 5'b00010 && !pass_start && !id_req_valid,
          "R10 observe held, R11 late done ignored", int'(status), 2);
    end
    chk(status[4:2] == 3'b000, "R12 unused status bits", int'(status[4:2]), 0);
    chk(exp_q.size() == 0, "R9 number of passes", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    run(1'b0, 3);
    run(1'b1, 0);
    run(1'b1, 5);
    run(1'b0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end
endmodule